// File: doc/BRIEF.md
# Configurable LFSR Pseudo-Random Generator

This block is a parameterised linear feedback shift register used as a pseudo-random source. At build time it takes a width, a tap mask, a structure (Fibonacci or Galois), a feedback polarity (XOR or XNOR), an optional reset seed, the number of single steps taken per enabled cycle, and a choice of whether a seed loaded at run time is also advanced in the cycle it is loaded.

At run time a consumer raises `increment` each time it wants fresh bits and reads the whole register from `stateOut`. The state can be replaced at any time by pulsing `seedValid` with a word on `seedWord`. A seed equal to the lock-up value (all zeros for XOR, all ones for XNOR) leaves the register stuck until the next reset, and reset always returns it to a value outside lock-up. Parameter sets that cannot work are rejected at elaboration: a width below 2, a step count below 1, a tap mask without its top bit, or a reset seed equal to the lock-up value.

Top module: `lfsr_prng`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `stateOut` equals the reset value: the seed parameter when one is given, otherwise 1 with XOR feedback and all ones except bit 0 with XNOR feedback.
- R2: When `increment` and `seedValid` are both low, `stateOut` keeps its value on the next cycle.
- R3: With same-cycle seed update off, a cycle with `seedValid` high makes `stateOut` equal that cycle's `seedWord` on the next cycle.
- R4: When `seedValid` and `increment` are high together, the seed load takes effect and the normal advance is not applied.
- R5: With same-cycle seed update on, the loaded seed is advanced by exactly one single step before it is stored; for a 4-bit Fibonacci XOR register with tap mask 4'b1100, loading 3 yields 6 on the next cycle.
- R6: With a step count of k, one enabled cycle applies k single steps; a 2-step instance enabled every second cycle and a 4-step instance enabled every fourth cycle match a 1-step instance enabled every cycle at the aligned points.
- R7: With a maximal-period tap mask, an n-bit register started from any non-lock-up value returns to it after exactly 2^n - 1 enabled cycles and never shows the same value on two consecutive advances.
- R8: A single step is defined as follows, with tap mask bit i selecting state bit i. Fibonacci: the state shifts toward the MSB and bit 0 takes the XOR (XNOR for XNOR feedback) of all tapped bits. Galois: the state shifts toward the LSB, the top bit takes the old bit 0, and every tapped bit i below the top becomes old bit i+1 XOR (XNOR) old bit 0.
- R9: Loading the lock-up value through the seed port leaves `stateOut` at the lock-up value while `increment` stays high.
- R10: In the cycle after reset is released, `stateOut` differs from the lock-up value, even when the register was stuck in lock-up before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| increment | input | 1 | Advance the register by the configured step count this cycle |
| seedValid | input | 1 | Replace the state with `seedWord` this cycle |
| seedWord | input | WIDTH | Seed value to load |
| stateOut | output | WIDTH | Current register state |

## Verification
The bench builds seven instances: 4-bit Fibonacci XOR registers with tap mask 4'b1100 at step counts 1, 2 and 4, which bring the aligned multi-step comparison and the lock-up cases within reach; a 4-bit instance with same-cycle seed update and a reset seed of 9, which reaches the seed-update arithmetic and the seed-parameter reset path; a 4-bit Fibonacci XNOR instance for the inverted lock-up value and default; and 8-bit Galois XOR and XNOR instances with tap mask 8'hB8, whose 255-cycle periods exercise the shift-toward-LSB structure. Every advance in the period runs is compared against a step model written from R8.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic {
    FORM_FIB = 1'b0,
    FORM_GAL = 1'b1
  } lfsrForm_e;

  typedef enum logic {
    FB_XOR  = 1'b0,
    FB_XNOR = 1'b1
  } lfsrFeedback_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic loadSeed;     // take the seed word this cycle
    logic advanceSeed;  // apply one step to the seed before storing it
    logic advance;      // apply the configured step count to the state
  } ctrlStrobes_t;

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int                     WIDTH    = 4,
  parameter lfsr_pkg::lfsrForm_e     FORM     = lfsr_pkg::FORM_FIB,
  parameter lfsr_pkg::lfsrFeedback_e FEEDBACK = lfsr_pkg::FB_XOR,
  parameter logic [WIDTH-1:0]       TAPS     = '1
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  localparam logic INV = (FEEDBACK == lfsr_pkg::FB_XNOR);

  generate
    if (FORM == lfsr_pkg::FORM_FIB) begin : g_fib
      logic fbBit;
      assign fbBit = (^(cur & TAPS)) ^ INV;
      assign nxt   = {cur[WIDTH-2:0], fbBit};
    end else begin : g_gal
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        if (gi == WIDTH - 1) begin : g_top
          assign nxt[gi] = cur[0];
        end else if (TAPS[gi]) begin : g_tap
          assign nxt[gi] = cur[gi+1] ^ cur[0] ^ INV;
        end else begin : g_pass
          assign nxt[gi] = cur[gi+1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lfsr_control.sv
module lfsr_control #(
  parameter bit UPDATE_SEED = 1'b0
) (
  input  logic                   increment,
  input  logic                   seedValid,
  output lfsr_pkg::ctrlStrobes_t strb
);

  always_comb begin
    strb             = '0;
    strb.loadSeed    = seedValid;
    strb.advanceSeed = seedValid && UPDATE_SEED;
    // a seed load wins over the normal advance
    strb.advance     = increment && !seedValid;
  end

endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath #(
  parameter int                     WIDTH       = 4,
  parameter int                     STEP        = 1,
  parameter lfsr_pkg::lfsrForm_e     FORM        = lfsr_pkg::FORM_FIB,
  parameter lfsr_pkg::lfsrFeedback_e FEEDBACK    = lfsr_pkg::FB_XOR,
  parameter logic [WIDTH-1:0]       TAPS        = '1,
  parameter logic [WIDTH-1:0]       RESET_VALUE = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  lfsr_pkg::ctrlStrobes_t strb,
  input  logic [WIDTH-1:0]       seedWord,
  output logic [WIDTH-1:0]       state
);

  localparam logic [WIDTH-1:0] LOCKUP =
    (FEEDBACK == lfsr_pkg::FB_XNOR) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [STEP:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]         seedNext;

  assign chain[0] = state;

  generate
    for (genvar k = 0; k < STEP; k++) begin : g_chain
      lfsr_step #(
        .WIDTH(WIDTH), .FORM(FORM), .FEEDBACK(FEEDBACK), .TAPS(TAPS)
      ) u_step (
        .cur(chain[k]),
        .nxt(chain[k+1])
      );
    end
  endgenerate

  lfsr_step #(
    .WIDTH(WIDTH), .FORM(FORM), .FEEDBACK(FEEDBACK), .TAPS(TAPS)
  ) u_seedStep (
    .cur(seedWord),
    .nxt(seedNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RESET_VALUE;
    end else if (strb.loadSeed) begin
      state <= strb.advanceSeed ? seedNext : seedWord;
    end else if (strb.advance) begin
      state <= chain[STEP];
    end
  end

  // a live (non lock-up) state always moves when advanced
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && state != LOCKUP) |=> (state != $past(state))); // R7

  // a stuck state stays stuck under advance
  AST_LOCKUP_STICKS: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && state == LOCKUP) |=> (state == LOCKUP)); // R9

endmodule

// File: rtl/lfsr_prng.sv
module lfsr_prng #(
  parameter int                     WIDTH       = 4,
  parameter int                     STEP        = 1,
  parameter lfsr_pkg::lfsrForm_e     FORM        = lfsr_pkg::FORM_FIB,
  parameter lfsr_pkg::lfsrFeedback_e FEEDBACK    = lfsr_pkg::FB_XOR,
  parameter logic [WIDTH-1:0]       TAPS        = 4'b1100,
  parameter bit                     HAS_SEED    = 1'b0,
  parameter logic [WIDTH-1:0]       SEED        = '0,
  parameter bit                     UPDATE_SEED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             increment,
  input  logic             seedValid,
  input  logic [WIDTH-1:0] seedWord,
  output logic [WIDTH-1:0] stateOut
);

  localparam bit               IS_XNOR = (FEEDBACK == lfsr_pkg::FB_XNOR);
  localparam logic [WIDTH-1:0] LOCKUP  = IS_XNOR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
  localparam logic [WIDTH-1:0] DEFAULT_VALUE =
    IS_XNOR ? ~{{(WIDTH-1){1'b0}}, 1'b1} : {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] RESET_VALUE = HAS_SEED ? SEED : DEFAULT_VALUE;

  generate
    if (WIDTH < 2) begin : g_badWidth
      $fatal(1, "lfsr_prng: WIDTH must be at least 2");
    end
    if (STEP < 1) begin : g_badStep
      $fatal(1, "lfsr_prng: STEP must be at least 1");
    end
    if (!TAPS[WIDTH-1]) begin : g_badTaps
      $fatal(1, "lfsr_prng: TAPS must include the top bit");
    end
    if (HAS_SEED && SEED == LOCKUP) begin : g_badSeed
      $fatal(1, "lfsr_prng: SEED equals the lock-up value");
    end
  endgenerate

  lfsr_pkg::ctrlStrobes_t strb;

  lfsr_control #(
    .UPDATE_SEED(UPDATE_SEED)
  ) u_control (
    .increment(increment),
    .seedValid(seedValid),
    .strb(strb)
  );

  lfsr_datapath #(
    .WIDTH(WIDTH), .STEP(STEP), .FORM(FORM), .FEEDBACK(FEEDBACK),
    .TAPS(TAPS), .RESET_VALUE(RESET_VALUE)
  ) u_datapath (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .seedWord(seedWord),
    .state(stateOut)
  );

  logic wasRst;
  always_ff @(posedge clk) wasRst <= rst;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wasRst |-> (stateOut == RESET_VALUE && stateOut != LOCKUP)); // R10

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!increment && !seedValid) |=> $stable(stateOut)); // R2

  generate
    if (!UPDATE_SEED) begin : g_plainLoad
      AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        seedValid |=> (stateOut == $past(seedWord))); // R4
    end
  endgenerate

endmodule

// File: tb/test_lfsr_prng.sv
module test_lfsr_prng;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // 0 A: fib xor step1 | 1 U: fib xor upd seed9 | 2 B: step2 | 3 C: step4
  // 4 FN: fib xnor | 5 GX: gal xor w8 | 6 GN: gal xnor w8
  logic       inc [7];
  logic       sv  [7];
  logic [7:0] sw  [7];
  logic [3:0] oA, oU, oB, oC, oFN;
  logic [7:0] oGX, oGN;

  lfsr_prng #(.WIDTH(4), .STEP(1), .TAPS(4'b1100)) i_lfsr_prng (
    .clk(clk), .rst(rst), .increment(inc[0]), .seedValid(sv[0]),
    .seedWord(sw[0][3:0]), .stateOut(oA));

  lfsr_prng #(.WIDTH(4), .STEP(1), .TAPS(4'b1100), .HAS_SEED(1'b1),
              .SEED(4'd9), .UPDATE_SEED(1'b1)) i_upd (
    .clk(clk), .rst(rst), .increment(inc[1]), .seedValid(sv[1]),
    .seedWord(sw[1][3:0]), .stateOut(oU));

  lfsr_prng #(.WIDTH(4), .STEP(2), .TAPS(4'b1100)) i_step2 (
    .clk(clk), .rst(rst), .increment(inc[2]), .seedValid(sv[2]),
    .seedWord(sw[2][3:0]), .stateOut(oB));

  lfsr_prng #(.WIDTH(4), .STEP(4), .TAPS(4'b1100)) i_step4 (
    .clk(clk), .rst(rst), .increment(inc[3]), .seedValid(sv[3]),
    .seedWord(sw[3][3:0]), .stateOut(oC));

  lfsr_prng #(.WIDTH(4), .FEEDBACK(lfsr_pkg::FB_XNOR), .TAPS(4'b1100)) i_fibXn (
    .clk(clk), .rst(rst), .increment(inc[4]), .seedValid(sv[4]),
    .seedWord(sw[4][3:0]), .stateOut(oFN));

  lfsr_prng #(.WIDTH(8), .FORM(lfsr_pkg::FORM_GAL), .TAPS(8'hB8)) i_galX (
    .clk(clk), .rst(rst), .increment(inc[5]), .seedValid(sv[5]),
    .seedWord(sw[5]), .stateOut(oGX));

  lfsr_prng #(.WIDTH(8), .FORM(lfsr_pkg::FORM_GAL), .FEEDBACK(lfsr_pkg::FB_XNOR),
              .TAPS(8'hB8)) i_galXn (
    .clk(clk), .rst(rst), .increment(inc[6]), .seedValid(sv[6]),
    .seedWord(sw[6]), .stateOut(oGN));

  function automatic logic [7:0] rd(input int idx);
    case (idx)
      0: return {4'h0, oA};
      1: return {4'h0, oU};
      2: return {4'h0, oB};
      3: return {4'h0, oC};
      4: return {4'h0, oFN};
      5: return oGX;
      default: return oGN;
    endcase
  endfunction

  // single step as defined in R8
  function automatic logic [7:0] refStep(input logic [7:0] s, input int w,
                                         input logic [7:0] taps, input bit gal,
                                         input bit xn);
    logic [7:0] n;
    logic       fb;
    n = '0;
    if (!gal) begin
      fb = xn;
      for (int i = 0; i < w; i++) if (taps[i]) fb = fb ^ s[i];
      for (int i = w - 1; i > 0; i--) n[i] = s[i-1];
      n[0] = fb;
    end else begin
      for (int i = 0; i < w - 1; i++)
        n[i] = taps[i] ? (s[i+1] ^ s[0] ^ xn) : s[i+1];
      n[w-1] = s[0];
    end
    return n;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic chkNe(input string what, input logic [7:0] act, input logic [7:0] bad);
    checks++;
    if (act === bad) begin
      errors++;
      $display("FAIL %s actual=%h expected anything but %h", what, act, bad);
    end
  endtask

  task automatic clearInputs();
    for (int i = 0; i < 7; i++) begin
      inc[i] = 1'b0; sv[i] = 1'b0; sw[i] = '0;
    end
  endtask

  task automatic testReset();
    chk("R1 fib xor default", rd(0), 8'h01);
    chk("R1 seed parameter", rd(1), 8'h09);
    chk("R1 step2 default", rd(2), 8'h01);
    chk("R1 step4 default", rd(3), 8'h01);
    chk("R1 fib xnor default", rd(4), 8'h0E);
    chk("R1 gal xor default", rd(5), 8'h01);
    chk("R1 gal xnor default", rd(6), 8'hFE);
  endtask

  task automatic testHold();
    sw[0] = 8'h07;  // present but not strobed
    repeat (3) tick();
    chk("R2 hold while idle", rd(0), 8'h01);
    sw[0] = '0;
  endtask

  task automatic testMultiStep();
    logic [7:0] model;
    model = 8'h01;
    for (int c = 0; c < 12; c++) begin
      inc[0] = 1'b1;
      inc[2] = (c % 2 == 1);
      inc[3] = (c % 4 == 3);
      tick();
      model = refStep(model, 4, 8'h0C, 1'b0, 1'b0);
      chk("R6 one-step model", rd(0), model);
      if (c % 2 == 1) chk("R6 two-step aligned", rd(2), rd(0));
      if (c % 4 == 3) chk("R6 four-step aligned", rd(3), rd(0));
    end
    inc[0] = 1'b0; inc[2] = 1'b0; inc[3] = 1'b0;
  endtask

  task automatic testSeedLoad();
    sv[0] = 1'b1; sw[0] = 8'h0A;
    tick();
    chk("R3 seed load", rd(0), 8'h0A);
    sw[0] = 8'h05; inc[0] = 1'b1;
    tick();
    chk("R4 seed beats increment", rd(0), 8'h05);
    sv[0] = 1'b0;
    tick();
    chk("R4 advance after load", rd(0), refStep(8'h05, 4, 8'h0C, 1'b0, 1'b0));
    inc[0] = 1'b0;
  endtask

  task automatic testUpdateSeed();
    sv[1] = 1'b1; sw[1] = 8'h03;
    tick();
    chk("R5 loaded seed advanced", rd(1), 8'h06);
    sw[1] = 8'h09; inc[1] = 1'b1;
    tick();
    chk("R5 one step with increment", rd(1), refStep(8'h09, 4, 8'h0C, 1'b0, 1'b0));
    sv[1] = 1'b0; inc[1] = 1'b0;
  endtask

  task automatic runPeriod(input int idx, input int w, input logic [7:0] taps,
                           input bit gal, input bit xn, input string name);
    logic [7:0] start, prev, cur;
    int n, badSteps, repeats;
    bit back;
    start = rd(idx); prev = start;
    n = 0; badSteps = 0; repeats = 0; back = 1'b0;
    inc[idx] = 1'b1;
    while (!back && n < 300) begin
      tick();
      n++;
      cur = rd(idx);
      if (cur !== refStep(prev, w, taps, gal, xn)) badSteps++;
      if (cur === prev) repeats++;
      if (cur === start) back = 1'b1;
      prev = cur;
    end
    inc[idx] = 1'b0;
    chk({"R7 period ", name}, 8'(n), 8'((1 << w) - 1));
    chk({"R7 no repeat ", name}, 8'(repeats), 8'h00);
    chk({"R8 step rule ", name}, 8'(badSteps), 8'h00);
  endtask

  task automatic testPeriods();
    runPeriod(0, 4, 8'h0C, 1'b0, 1'b0, "fib xor");
    runPeriod(4, 4, 8'h0C, 1'b0, 1'b1, "fib xnor");
    runPeriod(5, 8, 8'hB8, 1'b1, 1'b0, "gal xor");
    runPeriod(6, 8, 8'hB8, 1'b1, 1'b1, "gal xnor");
  endtask

  task automatic testLockup();
    sv[0] = 1'b1; sw[0] = 8'h00;
    sv[4] = 1'b1; sw[4] = 8'h0F;
    tick();
    sv[0] = 1'b0; sv[4] = 1'b0;
    inc[0] = 1'b1; inc[4] = 1'b1;
    repeat (3) tick();
    chk("R9 xor lock-up sticks", rd(0), 8'h00);
    chk("R9 xnor lock-up sticks", rd(4), 8'h0F);
  endtask

  task automatic testResetRecovery();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    inc[0] = 1'b0; inc[4] = 1'b0;
    chkNe("R10 xor leaves lock-up", rd(0), 8'h00);
    chkNe("R10 xnor leaves lock-up", rd(4), 8'h0F);
    chk("R10 xor back to default", rd(0), 8'h01);
  endtask

  initial begin
    clearInputs();
    repeat (3) tick();
    rst = 1'b0;
    testReset();
    testHold();
    testMultiStep();
    testSeedLoad();
    testUpdateSeed();
    testPeriods();
    testLockup();
    testResetRecovery();
    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule